// File: doc/BRIEF.md
# Descriptor-Linked DMA Channel Controller

This block sequences a single DMA channel that carries USB endpoint data. Firmware writes one control word. That word holds a 16-bit buffer length, a two-bit command, packet-closing enables, interrupt enables and a burst-lock bit. The block counts the buffer down as data beats arrive from the endpoint. It tracks how full an internal staging FIFO is, which the system bus side empties. It reports when the buffer runs out, when a short packet ends the transfer early, and when a new descriptor has been loaded. A masked interrupt line is formed from those three event flags.

The command pair {chain, run} has four meanings:

- **00 — stop now.** The channel halts immediately.
- **01 — run, stop at end.** The channel runs and stops when the buffer ends.
- **10 — fetch now.** A descriptor is fetched at once.
- **11 — run, then fetch.** The channel runs, and when the buffer ends it fetches the next descriptor.

A descriptor is fetched over a request/done handshake. The fetched word replaces the whole control word and reloads the counter.

The sequencer has four states:

- **IDLE.** Goes to RUN when the run bit is set. Otherwise goes to LOAD when the chain bit is set.
- **RUN.** Beats are accepted here. Goes to DRAIN when the run bit clears, when the counter hits zero, or when an enabled short packet arrives.
- **DRAIN.** No beats are accepted. Once the FIFO is empty, goes to LOAD if the chain bit is set, else to IDLE.
- **LOAD.** Waits for the descriptor handshake to complete. Goes to RUN if the loaded run bit is set, else to IDLE.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the channel is idle. The counter, control readback, FIFO level, event flags, validate pulse, descriptor request and interrupt are all zero.
- R2: A control write whose command is not 00 loads its length field into both the length register and the byte counter. A length of 0 loads 65536.
- R3: A control write with command 00 clears only control bits 1:0. The length register, the byte counter and control bits 7:2 keep their values.
- R4: In RUN with the run bit set, a beat is accepted when requested and the FIFO is not full. The counter then drops by beat_bytes (1 to 4) and saturates at zero.
- R5: A beat that brings a nonzero counter to zero sets the end-of-buffer flag. The same edge clears the run bit (control bit 0) and moves the channel to DRAIN.
- R6: pkt_validate pulses for one cycle, one edge after an end-of-buffer event, only if control bit 3 (end-of-buffer enable) is set.
- R7: A short_pkt seen in RUN with control bit 2 (end-of-transfer enable) set does three things: it sets the end-of-transfer flag, clears the run bit and closes the buffer. With bit 2 clear, short_pkt has no effect.
- R8: When the run bit clears during RUN, no further beats are accepted. chan_en stays high until the FIFO has emptied.
- R9: chan_act is high exactly while the FIFO holds at least one beat. It rises only after an accepted beat and falls only after a pop.
- R10: In LOAD, desc_req is high. On desc_done the control word and counter take desc_word and the descriptor-loaded flag sets. The channel then runs only if bit 0 of desc_word is set.
- R11: After an end of buffer with the chain bit (control bit 1) set, the channel drains and then requests a descriptor.
- R12: Clearing run and setting chain while data is in flight skips the current buffer. The counter moves no further, and a descriptor is requested once the FIFO is empty.
- R13: irq is the OR of each flag ANDed with its enable: end-of-buffer with bit 5, end-of-transfer with bit 4, descriptor-loaded with bit 6. sts_clr with a mask (bit0 buffer, bit1 transfer, bit2 loaded) clears flags, and a same-cycle set wins.
- R14: When a counter-zero beat and an enabled short packet fall in the same cycle, both the end-of-buffer and end-of-transfer flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: [31:16] length, [7:0] control bits |
| sts_clr | input | 1 | Flag clear strobe |
| sts_clr_mask | input | 3 | Flags to clear: bit0 buffer, bit1 transfer, bit2 loaded |
| beat_req | input | 1 | Endpoint offers a data beat |
| beat_bytes | input | 3 | Bytes in the offered beat, 1 to 4 |
| beat_ack | output | 1 | Beat accepted this cycle |
| short_pkt | input | 1 | Endpoint signals a short packet |
| bus_pop | input | 1 | Bus side takes one beat from the FIFO |
| desc_req | output | 1 | Descriptor fetch request |
| desc_done | input | 1 | Descriptor fetch complete |
| desc_word | input | 32 | Fetched descriptor control word |
| ctrl_q | output | 32 | Control readback: length, zeros, control bits |
| byte_cnt | output | 17 | Remaining byte count |
| chan_en | output | 1 | Channel enabled (RUN or DRAIN) |
| chan_act | output | 1 | FIFO holds data |
| eob_flag | output | 1 | End-of-buffer event flag |
| eot_flag | output | 1 | End-of-transfer event flag |
| dld_flag | output | 1 | Descriptor-loaded event flag |
| pkt_validate | output | 1 | Packet validate pulse at buffer end |
| burst_lock | output | 1 | Burst lock request (control bit 7) |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can fall in the same cycle. The first is the counter-zero event, which closes the buffer. The second is either an enabled short packet or a firmware flag clear. The bench provokes each pairing by driving, at one negedge, a beat that exactly empties the counter together with short_pkt, or together with sts_clr on the end-of-buffer bit. It then judges the outcome against a behavioural model that sets both flags, and lets the set beat the clear. The model is compared with every output on every cycle, so the drain and skip orderings around those edges are judged as well.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_LOAD  = 2'd3
    } ch_state_e;

    // Control bits, bit 7 down to bit 0
    typedef struct packed {
        logic lock;     // 7 burst lock
        logic dld_ie;   // 6 descriptor-loaded interrupt enable
        logic eob_ie;   // 5 end-of-buffer interrupt enable
        logic eot_ie;   // 4 end-of-transfer interrupt enable
        logic eob_en;   // 3 validate packet at buffer end
        logic eot_en;   // 2 short packet closes buffer
        logic chain;    // 1 command: fetch next descriptor
        logic run;      // 0 command: enable channel
    } ctrl_bits_t;

    localparam int unsigned CTRL_W = 8;
    localparam int unsigned FLAG_N = 3;

endpackage

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              dec,
    input  logic [BEAT_W-1:0] dec_bytes,
    output logic [LEN_W:0]    cnt,
    output logic              hit_zero
);
    localparam int unsigned CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_dec;

    always_comb begin
        step     = {{(CNT_W-BEAT_W){1'b0}}, dec_bytes};
        cnt_dec  = (cnt > step) ? (cnt - step) : '0;
        hit_zero = dec && (cnt != '0) && (cnt <= step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, load_len};
        end else if (dec) begin
            cnt <= cnt_dec;
        end
    end

endmodule

// File: rtl/dma_fifo_level.sv
module dma_fifo_level #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop_req,
    output logic full,
    output logic empty
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] level;
    logic             pop;

    always_comb begin
        empty = (level == '0);
        full  = (level == LVL_W'(DEPTH));
        pop   = pop_req && !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_run,
    input  logic      cmd_chain,
    input  logic      hit_zero,
    input  logic      short_in,
    input  logic      eot_en,
    input  logic      fifo_empty,
    input  logic      desc_done,
    input  logic      desc_run,
    output ch_state_e state,
    output logic      beat_en,
    output logic      chan_en,
    output logic      desc_req,
    output logic      eot_evt,
    output logic      dld_evt,
    output logic      close_evt
);
    ch_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        beat_en   = 1'b0;
        chan_en   = 1'b0;
        desc_req  = 1'b0;
        eot_evt   = 1'b0;
        dld_evt   = 1'b0;
        close_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_run)        state_nx = ST_RUN;
                else if (cmd_chain) state_nx = ST_LOAD;
            end
            ST_RUN: begin
                chan_en   = 1'b1;
                beat_en   = cmd_run;
                eot_evt   = cmd_run && short_in && eot_en;
                close_evt = hit_zero || eot_evt;
                if (!cmd_run || close_evt) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                chan_en = 1'b1;
                if (fifo_empty) state_nx = cmd_chain ? ST_LOAD : ST_IDLE;
            end
            ST_LOAD: begin
                desc_req = 1'b1;
                dld_evt  = desc_done;
                if (desc_done) state_nx = desc_run ? ST_RUN : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned BEAT_W     = 3,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [LEN_W+15:0] cfg_wdata,
    input  logic              sts_clr,
    input  logic [2:0]        sts_clr_mask,
    input  logic              beat_req,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              beat_ack,
    input  logic              short_pkt,
    input  logic              bus_pop,
    output logic              desc_req,
    input  logic              desc_done,
    input  logic [LEN_W+15:0] desc_word,
    output logic [LEN_W+15:0] ctrl_q,
    output logic [LEN_W:0]    byte_cnt,
    output logic              chan_en,
    output logic              chan_act,
    output logic              eob_flag,
    output logic              eot_flag,
    output logic              dld_flag,
    output logic              pkt_validate,
    output logic              burst_lock,
    output logic              irq
);
    localparam int unsigned WORD_W = LEN_W + 16;

    ctrl_bits_t       ctrl;
    logic [LEN_W-1:0] len_q;
    ch_state_e        state;
    logic             beat_en, fifo_full, fifo_empty;
    logic             hit_zero, eot_evt, dld_evt, close_evt;
    logic             wr_stop, wr_full, cnt_load;
    logic [LEN_W-1:0] cnt_len;

    always_comb begin
        wr_stop  = cfg_wr && (cfg_wdata[1:0] == 2'b00);
        wr_full  = cfg_wr && (cfg_wdata[1:0] != 2'b00);
        beat_ack = beat_en && beat_req && !fifo_full;
        cnt_load = dld_evt || wr_full;
        cnt_len  = dld_evt ? desc_word[WORD_W-1:16] : cfg_wdata[WORD_W-1:16];
    end

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_run    (ctrl.run),
        .cmd_chain  (ctrl.chain),
        .hit_zero   (hit_zero),
        .short_in   (short_pkt),
        .eot_en     (ctrl.eot_en),
        .fifo_empty (fifo_empty),
        .desc_done  (desc_done),
        .desc_run   (desc_word[0]),
        .state      (state),
        .beat_en    (beat_en),
        .chan_en    (chan_en),
        .desc_req   (desc_req),
        .eot_evt    (eot_evt),
        .dld_evt    (dld_evt),
        .close_evt  (close_evt)
    );

    dma_byte_counter #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_len  (cnt_len),
        .dec       (beat_ack),
        .dec_bytes (beat_bytes),
        .cnt       (byte_cnt),
        .hit_zero  (hit_zero)
    );

    dma_fifo_level #(.DEPTH(FIFO_DEPTH)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (beat_ack),
        .pop_req (bus_pop),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    // control word: descriptor load, then firmware, then hardware clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            len_q <= '0;
        end else if (dld_evt) begin
            ctrl  <= ctrl_bits_t'(desc_word[CTRL_W-1:0]);
            len_q <= desc_word[WORD_W-1:16];
        end else if (wr_full) begin
            ctrl  <= ctrl_bits_t'(cfg_wdata[CTRL_W-1:0]);
            len_q <= cfg_wdata[WORD_W-1:16];
        end else if (wr_stop) begin
            ctrl.run   <= 1'b0;
            ctrl.chain <= 1'b0;
        end else if (close_evt) begin
            ctrl.run <= 1'b0;
        end
    end

    // event flags: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eob_flag     <= 1'b0;
            eot_flag     <= 1'b0;
            dld_flag     <= 1'b0;
            pkt_validate <= 1'b0;
        end else begin
            eob_flag     <= (eob_flag && !(sts_clr && sts_clr_mask[0])) || hit_zero;
            eot_flag     <= (eot_flag && !(sts_clr && sts_clr_mask[1])) || eot_evt;
            dld_flag     <= (dld_flag && !(sts_clr && sts_clr_mask[2])) || dld_evt;
            pkt_validate <= hit_zero && ctrl.eob_en;
        end
    end

    always_comb begin
        chan_act   = !fifo_empty;
        burst_lock = ctrl.lock;
        ctrl_q     = {len_q, 8'h00, ctrl};
        irq        = (eob_flag && ctrl.eob_ie) || (eot_flag && ctrl.eot_ie)
                   || (dld_flag && ctrl.dld_ie);
    end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic        sts_clr,
    input logic [2:0]  sts_clr_mask,
    input logic        beat_req,
    input logic [2:0]  beat_bytes,
    input logic        beat_ack,
    input logic        short_pkt,
    input logic        bus_pop,
    input logic        desc_req,
    input logic        desc_done,
    input logic [31:0] desc_word,
    input logic [31:0] ctrl_q,
    input logic [16:0] byte_cnt,
    input logic        chan_en,
    input logic        chan_act,
    input logic        eob_flag,
    input logic        eot_flag,
    input logic        dld_flag,
    input logic        pkt_validate,
    input logic        burst_lock,
    input logic        irq
);
    assert_len_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1:0] != 2'b00 && cfg_wdata[31:16] == 16'd0 && !desc_req)
        |=> byte_cnt == 17'h10000);

    assert_stop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1:0] == 2'b00 && !desc_req) |=> $stable(ctrl_q[31:2]));

    assert_cnt_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && !cfg_wr) |=> byte_cnt <= $past(byte_cnt));

    assert_ack_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> chan_en);

    assert_en_after_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_en) |-> !chan_act);

    assert_act_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_act) |-> $past(beat_ack));

    assert_act_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_act) |-> $past(bus_pop));

    assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> !chan_en);

    assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(eob_flag || eot_flag || dld_flag) |-> !irq);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (.*);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sts_clr = 1'b0;
    logic [2:0]  sts_clr_mask = '0;
    logic        beat_req = 1'b0;
    logic [2:0]  beat_bytes = 3'd1;
    logic        beat_ack;
    logic        short_pkt = 1'b0;
    logic        bus_pop = 1'b0;
    logic        desc_req;
    logic        desc_done = 1'b0;
    logic [31:0] desc_word = '0;
    logic [31:0] ctrl_q;
    logic [16:0] byte_cnt;
    logic        chan_en, chan_act, eob_flag, eot_flag, dld_flag;
    logic        pkt_validate, burst_lock, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_chan_ctrl u0 (.*);

    // behavioural reference model
    int         m_st = 0;     // 0 idle, 1 run, 2 drain, 3 load
    logic [7:0] m_ctrl = '0;
    int         m_len = 0;
    int         m_cnt = 0;
    int         m_lvl = 0;
    bit         m_eob = 0, m_eot = 0, m_dld = 0, m_val = 0;

    function automatic int len_of(input logic [15:0] l);
        return (l == 16'd0) ? 65536 : int'(l);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ctrl = '0; m_len = 0; m_cnt = 0; m_lvl = 0;
            m_eob = 0; m_eot = 0; m_dld = 0; m_val = 0;
        end else begin
            bit ack, pop, hz, eot, dld;
            int ns;
            ack = (m_st == 1) && m_ctrl[0] && beat_req && (m_lvl < 4);
            pop = bus_pop && (m_lvl > 0);
            hz  = ack && (m_cnt > 0) && (m_cnt <= int'(beat_bytes));
            eot = (m_st == 1) && m_ctrl[0] && short_pkt && m_ctrl[2];
            dld = (m_st == 3) && desc_done;
            ns  = m_st;
            case (m_st)
                0: if (m_ctrl[0]) ns = 1; else if (m_ctrl[1]) ns = 3;
                1: if (!m_ctrl[0] || hz || eot) ns = 2;
                2: if (m_lvl == 0) ns = m_ctrl[1] ? 3 : 0;
                default: if (desc_done) ns = desc_word[0] ? 1 : 0;
            endcase
            m_val = hz && m_ctrl[3];
            if (dld) m_cnt = len_of(desc_word[31:16]);
            else if (cfg_wr && cfg_wdata[1:0] != 2'b00) m_cnt = len_of(cfg_wdata[31:16]);
            else if (ack) m_cnt = (m_cnt > int'(beat_bytes)) ? m_cnt - int'(beat_bytes) : 0;
            if (dld) begin
                m_ctrl = desc_word[7:0]; m_len = int'(desc_word[31:16]);
            end else if (cfg_wr) begin
                if (cfg_wdata[1:0] == 2'b00) m_ctrl[1:0] = 2'b00;
                else begin m_ctrl = cfg_wdata[7:0]; m_len = int'(cfg_wdata[31:16]); end
            end else if (hz || eot) m_ctrl[0] = 1'b0;
            m_lvl = m_lvl + int'(ack) - int'(pop);
            m_eob = (m_eob && !(sts_clr && sts_clr_mask[0])) || hz;
            m_eot = (m_eot && !(sts_clr && sts_clr_mask[1])) || eot;
            m_dld = (m_dld && !(sts_clr && sts_clr_mask[2])) || dld;
            m_st  = ns;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R8", "chan_en", longint'(chan_en), longint'(m_st == 1 || m_st == 2));
            chk("R9", "chan_act", longint'(chan_act), longint'(m_lvl > 0));
            chk("R4", "byte_cnt", longint'(byte_cnt), longint'(m_cnt));
            chk("R5", "eob_flag", longint'(eob_flag), longint'(m_eob));
            chk("R7", "eot_flag", longint'(eot_flag), longint'(m_eot));
            chk("R10", "dld_flag", longint'(dld_flag), longint'(m_dld));
            chk("R10", "desc_req", longint'(desc_req), longint'(m_st == 3));
            chk("R6", "pkt_validate", longint'(pkt_validate), longint'(m_val));
            chk("R3", "ctrl_q", longint'(ctrl_q), (longint'(m_len) << 16) | longint'(m_ctrl));
            chk("R13", "irq", longint'(irq),
                longint'((m_eob && m_ctrl[5]) || (m_eot && m_ctrl[4]) || (m_dld && m_ctrl[6])));
            chk("R8", "beat_ack", longint'(beat_ack),
                longint'(m_st == 1 && m_ctrl[0] && beat_req && m_lvl < 4));
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic hold(input bit req, input int b, input bit pop, input bit sp, input int n);
        @(negedge clk);
        beat_req = req; beat_bytes = 3'(b); bus_pop = pop; short_pkt = sp;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk); sts_clr = 1'b1; sts_clr_mask = m;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    task automatic desc(input logic [31:0] w);
        @(negedge clk); desc_done = 1'b1; desc_word = w;
        @(negedge clk); desc_done = 1'b0;
    endtask

    task automatic settle();
        hold(0, 1, 1, 0, 1);
        for (int i = 0; i < 40 && chan_en; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "byte_cnt", longint'(byte_cnt), 0);
        chk("R1", "ctrl_q", longint'(ctrl_q), 0);
        chk("R1", "chan_en", longint'(chan_en), 0);
        chk("R1", "irq", longint'(irq), 0);

        // R2 / R3: length load, zero length, stop-now write
        wr(32'h0000_0001); #1 chk("R2", "len 0 count", longint'(byte_cnt), 65536);
        wr(32'h000A_0001); #1 chk("R2", "len 10 count", longint'(byte_cnt), 10);
        wr(32'hFFFF_00FC); #1 chk("R3", "stop keeps len", longint'(ctrl_q), 32'h000A_0000);
        chk("R3", "stop keeps count", longint'(byte_cnt), 10);
        settle();

        // R4 / R5 / R6: 3-byte beats, saturating at zero
        wr(32'h0007_0029);
        hold(1, 3, 1, 0, 4);
        hold(0, 1, 1, 0, 1); #1;
        chk("R4", "count saturated", longint'(byte_cnt), 0);
        chk("R5", "eob flag", longint'(eob_flag), 1);
        chk("R13", "irq eob", longint'(irq), 1);
        settle();
        clr(3'b001); #1 chk("R13", "cleared irq", longint'(irq), 0);

        // R8 / R9: disable with data in flight
        wr(32'h0064_0001);
        hold(1, 4, 0, 0, 4);
        wr(32'h0000_0000);
        hold(1, 4, 0, 0, 3); #1;
        chk("R8", "still enabled", longint'(chan_en), 1);
        chk("R8", "no ack while draining", longint'(beat_ack), 0);
        chk("R9", "active with data", longint'(chan_act), 1);
        hold(0, 1, 1, 0, 6); #1;
        chk("R8", "disabled after drain", longint'(chan_en), 0);
        chk("R9", "inactive when empty", longint'(chan_act), 0);

        // R7: short packet closes buffer when enabled
        wr(32'h0032_0015);
        hold(1, 4, 1, 0, 3);
        hold(1, 4, 1, 1, 1);
        hold(0, 1, 1, 0, 3); #1;
        chk("R7", "eot flag", longint'(eot_flag), 1);
        chk("R7", "closed", longint'(chan_en), 0);
        clr(3'b111);
        // R7: ignored when disabled
        wr(32'h0032_0001);
        hold(0, 1, 1, 0, 2);
        hold(0, 1, 1, 1, 1);
        hold(0, 1, 1, 0, 2); #1;
        chk("R7", "short ignored, running", longint'(chan_en), 1);
        chk("R7", "short ignored, no flag", longint'(eot_flag), 0);
        wr(32'h0000_0000); settle();

        // R14: counter zero and short packet in one cycle
        wr(32'h0004_000D);
        hold(0, 1, 1, 0, 1);
        hold(1, 4, 1, 1, 1);
        hold(0, 1, 1, 0, 3); #1;
        chk("R14", "eob with eot", longint'(eob_flag), 1);
        chk("R14", "eot with eob", longint'(eot_flag), 1);
        clr(3'b111);

        // R10: immediate descriptor load
        wr(32'h0000_0042);
        hold(0, 1, 1, 0, 2); #1 chk("R10", "desc_req", longint'(desc_req), 1);
        desc(32'h0020_0041); #1;
        chk("R10", "loaded count", longint'(byte_cnt), 32);
        chk("R10", "loaded runs", longint'(chan_en), 1);
        chk("R13", "irq dld", longint'(irq), 1);
        wr(32'h0000_0000); settle(); clr(3'b100);
        wr(32'h0000_0002);
        hold(0, 1, 1, 0, 2);
        desc(32'h0010_0000); #1;
        chk("R10", "loaded stays idle", longint'(chan_en), 0);

        // R11: run then fetch at end of buffer
        wr(32'h0004_0003);
        hold(0, 1, 1, 0, 1);
        hold(1, 4, 1, 0, 1);
        hold(0, 1, 1, 0, 3); #1 chk("R11", "fetch after end", longint'(desc_req), 1);
        desc(32'h0008_0000); #1 chk("R11", "next count", longint'(byte_cnt), 8);

        // R12: skip current buffer
        wr(32'h0028_0001);
        hold(1, 4, 0, 0, 3);
        wr(32'h0028_0002);
        hold(1, 4, 0, 0, 3); #1 chk("R12", "no beats on skip", longint'(beat_ack), 0);
        hold(0, 1, 1, 0, 6); #1;
        chk("R12", "fetch after skip", longint'(desc_req), 1);
        chk("R12", "count untouched", longint'(byte_cnt), 40);
        desc(32'h0000_0000);

        // R13: set beats clear in the same cycle
        clr(3'b111);
        wr(32'h0002_0021);
        hold(0, 1, 1, 0, 1);
        @(negedge clk); beat_req = 1'b1; beat_bytes = 3'd2; sts_clr = 1'b1; sts_clr_mask = 3'b001;
        @(negedge clk); beat_req = 1'b0; sts_clr = 1'b0; #1;
        chk("R13", "set wins", longint'(eob_flag), 1);
        settle();

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule